// File: doc/BRIEF.md
# Dual-Direction FIFO and Mailbox Host Port

This block sits between a host bus and a board processor and gives the host a small window of eight byte offsets. Through it the host sends 16-bit entries into an outbound FIFO and drains an inbound FIFO. It also exchanges 6-bit messages through a pair of single-entry mailboxes, reads a status byte of level flags and writes an interrupt enable register. A write to a dedicated offset resets the link. The board sees the outbound FIFO as a valid/ready source and the inbound FIFO as a valid/ready sink. It sees each mailbox through a data bus, a full flag and a one-cycle strobe.

Host accesses are single-cycle strobes. Read data is presented combinationally while `h_rd` is high, and any side effect of the read, such as a FIFO pop or a mailbox clear, takes place at the clock edge that ends the strobe. On the board side, `ob_valid` stays high while the outbound FIFO holds an entry, and `ob_data` holds the oldest entry until the cycle in which `ob_ready` is high. `ib_ready` is low while the inbound FIFO is full, and an entry is taken on every edge where `ib_valid` and `ib_ready` are both high.

The `word_mode` input sets the usable FIFO capacity. In word mode each FIFO holds `DEPTH` entries. In byte mode each FIFO holds `DEPTH/2` entries. `DEPTH` must be even.

Top module: `hostlink_if`

## Requirements
- R1: After reset both FIFOs are empty, both mailboxes are clear, the interrupt enables and the readback select are zero, `host_irq` is low, and a status read returns 0x21.
- R2: A host write at offset 0 pushes one outbound entry. With `h_hi_en` high the entry is `h_wdata`; with it low the entry is `{8'h00, h_wdata[7:0]}`. `ob_valid` is high exactly while the outbound FIFO is non-empty. `ob_data` shows the oldest entry and holds it until a cycle with `ob_ready` high pops it.
- R3: A host read at offset 0 pops one inbound entry. It returns the full entry when `h_hi_en` is high and `{8'h00, low byte}` otherwise. Entries come out in arrival order.
- R4: The capacity of each FIFO is `DEPTH` entries when `word_mode` is 1 and `DEPTH/2` entries when it is 0. A push into a full FIFO is ignored and `ib_ready` is low while the inbound FIFO is full. A pop from an empty FIFO is ignored and returns 0.
- R5: The status byte is read at offset 2. Its bits are: 7 outbound mailbox not yet taken by the board, 6 outbound full, 5 inbound empty, 4 outbound at least half of capacity, 3 inbound at least half of capacity, 2 inbound mailbox full, 1 inbound full, 0 outbound empty.
- R6: The mask register is written at offset 2 and cannot be read. Its bits are: 7 mailbox readback select, 6 enable on inbound mailbox full, 5 enable on inbound full, 3 enable on inbound empty, 2 enable on outbound full, 0 enable on outbound empty. Bits 4 and 1 are ignored. `host_irq` is high while the interrupt gate is open and any enabled condition holds.
- R7: The interrupt gate is closed at reset and by an offset-7 write. It opens on the edge after a `bd_irq_enable` pulse. An offset-7 write in the same cycle takes priority.
- R8: Mailboxes hold 6 bits, which are written from `h_wdata[7:2]`, and a read returns them in bits 7..2 with bits 1..0 zero. A read at offset 3 returns the inbound mailbox when readback select is 0 and the outbound mailbox when it is 1. A write at offset 3 always loads the outbound mailbox.
- R9: A host mailbox write sets the outbound full flag, and a `bd_omb_take` clears the flag without changing the contents. A `bd_imb_put` loads the inbound mailbox and sets its full flag. A host read at offset 3 with readback select 0 clears that flag. A load in the same cycle as a clear wins.
- R10: Any write at offset 7 empties both FIFOs, clears both mailboxes (data and flags), clears the mask and closes the gate, and `board_rst` is high for exactly the next cycle. A read at offset 7 returns 0 and changes nothing.
- R11: Writes at offsets 1, 4, 5 and 6 change nothing, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_mode | input | 1 | 1: full FIFO capacity, 0: half capacity |
| h_addr | input | 3 | Host offset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_hi_en | input | 1 | High byte lane enable (word access) |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data, valid while `h_rd` is high |
| ob_valid | output | 1 | Outbound entry available |
| ob_ready | input | 1 | Board takes the outbound entry |
| ob_data | output | 16 | Oldest outbound entry |
| ib_valid | input | 1 | Board offers an inbound entry |
| ib_ready | output | 1 | Inbound FIFO has room |
| ib_data | input | 16 | Inbound entry |
| bd_omb_data | output | 6 | Outbound mailbox contents |
| bd_omb_full | output | 1 | Outbound mailbox not yet taken |
| bd_omb_take | input | 1 | Board consumes the outbound mailbox |
| bd_imb_put | input | 1 | Board loads the inbound mailbox |
| bd_imb_data | input | 6 | Inbound mailbox data |
| bd_imb_full | output | 1 | Inbound mailbox not yet read by host |
| bd_irq_enable | input | 1 | Pulse that opens the host interrupt gate |
| host_irq | output | 1 | Host interrupt level |
| board_rst | output | 1 | One-cycle reset request to the board |

## Verification
A wrong FIFO occupancy count shows in the same cycle as a wrong `ib_ready` or a wrong status flag, and a later push or pop is then accepted or dropped wrongly. A damaged read or write pointer shows as a wrong `ob_data` or a wrong offset-0 read value at the next pop. A wrong mask or gate bit shows on `host_irq` from the cycle after the write or pulse, as soon as the enabled condition is present. A wrong mailbox flag shows at once on `bd_omb_full`, `bd_imb_full` or status bits 7 and 2. A reference model runs alongside the design and compares every output on every cycle, so any of these faults is reported in the cycle it first reaches a port.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;

  // host window offsets
  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_CTRL  = 3'd2;
  localparam logic [2:0] OFS_MBOX  = 3'd3;
  localparam logic [2:0] OFS_RESET = 3'd7;

  // status byte bit positions
  localparam int ST_OMB_PEND = 7;
  localparam int ST_OB_FULL  = 6;
  localparam int ST_IB_EMPTY = 5;
  localparam int ST_OB_HALF  = 4;
  localparam int ST_IB_HALF  = 3;
  localparam int ST_IMB_FULL = 2;
  localparam int ST_IB_FULL  = 1;
  localparam int ST_OB_EMPTY = 0;

  // mask byte bit positions
  localparam int MK_RSEL     = 7;
  localparam int MK_IMB      = 6;
  localparam int MK_IB_FULL  = 5;
  localparam int MK_IB_EMPTY = 3;
  localparam int MK_OB_FULL  = 2;
  localparam int MK_OB_EMPTY = 0;

  localparam int MB_W = 6;

  typedef struct packed {
    logic rsel;
    logic en_imb;
    logic en_ib_full;
    logic en_ib_empty;
    logic en_ob_full;
    logic en_ob_empty;
  } mask_t;

endpackage

// File: rtl/hl_fifo.sv
module hl_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             word_mode,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full,
  output logic             half
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CAP_WORD = CW'(DEPTH);
  localparam logic [CW-1:0] CAP_BYTE = CW'(DEPTH / 2);
  localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt, limit;
  logic             do_push, do_pop;

  assign limit   = word_mode ? CAP_WORD : CAP_BYTE;
  assign full    = (cnt >= limit);
  assign empty   = (cnt == '0);
  assign half    = (cnt >= (limit >> 1));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= push_data;
  end

  // R4: a push into a full FIFO leaves the occupancy unchanged
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> (cnt == $past(cnt)));

  // R4: a pop from an empty FIFO leaves it empty
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !clr) |=> (cnt == '0));

  // R4: occupancy never exceeds the physical depth
  a_r4_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (cnt <= CAP_WORD));

endmodule

// File: rtl/hl_mbox.sv
module hl_mbox #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         put,
  input  logic [W-1:0] put_data,
  input  logic         take,
  output logic [W-1:0] data,
  output logic         full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      full <= 1'b0;
    end else if (clr) begin
      data <= '0;
      full <= 1'b0;
    end else if (put) begin
      data <= put_data;
      full <= 1'b1;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  // R9: a load sets the flag even against a simultaneous take
  a_r9_put_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (put && !clr) |=> full);

  // R9: a take clears the flag
  a_r9_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !put && !clr) |=> !full);

  // R9: a take leaves the contents in place
  a_r9_take_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !put && !clr) |=> $stable(data));

endmodule

// File: rtl/hl_ctrl.sv
module hl_ctrl
  import hostlink_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  mask_wr,
  input  mask_t mask_in,
  input  logic  gate_set,
  input  logic  c_imb_full,
  input  logic  c_ib_full,
  input  logic  c_ib_empty,
  input  logic  c_ob_full,
  input  logic  c_ob_empty,
  output logic  rsel,
  output logic  irq
);
  mask_t m;
  logic  gate;
  logic  cause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m    <= '0;
      gate <= 1'b0;
    end else if (clr) begin
      m    <= '0;
      gate <= 1'b0;
    end else begin
      if (mask_wr)  m    <= mask_in;
      if (gate_set) gate <= 1'b1;
    end
  end

  assign cause = (m.en_imb      && c_imb_full) ||
                 (m.en_ib_full  && c_ib_full)  ||
                 (m.en_ib_empty && c_ib_empty) ||
                 (m.en_ob_full  && c_ob_full)  ||
                 (m.en_ob_empty && c_ob_empty);
  assign irq  = gate && cause;
  assign rsel = m.rsel;

  // R7: a link reset silences the interrupt on the following cycle
  a_r7_clear_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !irq);

endmodule

// File: rtl/hostlink_if.sv
module hostlink_if
  import hostlink_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            word_mode,
  input  logic [2:0]      h_addr,
  input  logic            h_wr,
  input  logic            h_rd,
  input  logic            h_hi_en,
  input  logic [15:0]     h_wdata,
  output logic [15:0]     h_rdata,
  output logic            ob_valid,
  input  logic            ob_ready,
  output logic [15:0]     ob_data,
  input  logic            ib_valid,
  output logic            ib_ready,
  input  logic [15:0]     ib_data,
  output logic [MB_W-1:0] bd_omb_data,
  output logic            bd_omb_full,
  input  logic            bd_omb_take,
  input  logic            bd_imb_put,
  input  logic [MB_W-1:0] bd_imb_data,
  output logic            bd_imb_full,
  input  logic            bd_irq_enable,
  output logic            host_irq,
  output logic            board_rst
);
  localparam int DW = 16;

  logic wr_data, rd_data, wr_ctrl, wr_mbox, rd_mbox, wr_reset;
  logic [DW-1:0] push_word;
  logic ob_empty, ob_full, ob_half;
  logic ib_empty, ib_full, ib_half;
  logic [DW-1:0] ib_head;
  logic [MB_W-1:0] imb_data;
  logic rsel;
  mask_t mask_new;
  logic [7:0] status;
  logic [7:0] mb_view;
  logic board_rst_q;

  // host decode
  assign wr_data  = h_wr && (h_addr == OFS_DATA);
  assign rd_data  = h_rd && (h_addr == OFS_DATA);
  assign wr_ctrl  = h_wr && (h_addr == OFS_CTRL);
  assign wr_mbox  = h_wr && (h_addr == OFS_MBOX);
  assign rd_mbox  = h_rd && (h_addr == OFS_MBOX);
  assign wr_reset = h_wr && (h_addr == OFS_RESET);

  assign push_word = h_hi_en ? h_wdata : {8'h00, h_wdata[7:0]};

  hl_fifo #(.DEPTH(DEPTH), .WIDTH(DW)) u_ob_fifo (
    .clk(clk), .rst_n(rst_n), .clr(wr_reset), .word_mode(word_mode),
    .push(wr_data), .push_data(push_word), .pop(ob_ready),
    .head(ob_data), .empty(ob_empty), .full(ob_full), .half(ob_half)
  );

  hl_fifo #(.DEPTH(DEPTH), .WIDTH(DW)) u_ib_fifo (
    .clk(clk), .rst_n(rst_n), .clr(wr_reset), .word_mode(word_mode),
    .push(ib_valid), .push_data(ib_data), .pop(rd_data),
    .head(ib_head), .empty(ib_empty), .full(ib_full), .half(ib_half)
  );

  assign ob_valid = !ob_empty;
  assign ib_ready = !ib_full;

  hl_mbox #(.W(MB_W)) u_omb (
    .clk(clk), .rst_n(rst_n), .clr(wr_reset),
    .put(wr_mbox), .put_data(h_wdata[7:2]), .take(bd_omb_take),
    .data(bd_omb_data), .full(bd_omb_full)
  );

  hl_mbox #(.W(MB_W)) u_imb (
    .clk(clk), .rst_n(rst_n), .clr(wr_reset),
    .put(bd_imb_put), .put_data(bd_imb_data), .take(rd_mbox && !rsel),
    .data(imb_data), .full(bd_imb_full)
  );

  always_comb begin
    mask_new.rsel        = h_wdata[MK_RSEL];
    mask_new.en_imb      = h_wdata[MK_IMB];
    mask_new.en_ib_full  = h_wdata[MK_IB_FULL];
    mask_new.en_ib_empty = h_wdata[MK_IB_EMPTY];
    mask_new.en_ob_full  = h_wdata[MK_OB_FULL];
    mask_new.en_ob_empty = h_wdata[MK_OB_EMPTY];
  end

  hl_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(wr_reset),
    .mask_wr(wr_ctrl), .mask_in(mask_new), .gate_set(bd_irq_enable),
    .c_imb_full(bd_imb_full), .c_ib_full(ib_full), .c_ib_empty(ib_empty),
    .c_ob_full(ob_full), .c_ob_empty(ob_empty),
    .rsel(rsel), .irq(host_irq)
  );

  always_comb begin
    status              = '0;
    status[ST_OMB_PEND] = bd_omb_full;
    status[ST_OB_FULL]  = ob_full;
    status[ST_IB_EMPTY] = ib_empty;
    status[ST_OB_HALF]  = ob_half;
    status[ST_IB_HALF]  = ib_half;
    status[ST_IMB_FULL] = bd_imb_full;
    status[ST_IB_FULL]  = ib_full;
    status[ST_OB_EMPTY] = ob_empty;
  end

  assign mb_view = {(rsel ? bd_omb_data : imb_data), 2'b00};

  always_comb begin
    h_rdata = '0;
    if (h_rd) begin
      unique case (h_addr)
        OFS_DATA: if (!ib_empty) h_rdata = h_hi_en ? ib_head : {8'h00, ib_head[7:0]};
        OFS_CTRL: h_rdata = {8'h00, status};
        OFS_MBOX: h_rdata = {8'h00, mb_view};
        default:  h_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) board_rst_q <= 1'b0;
    else        board_rst_q <= wr_reset;
  end
  assign board_rst = board_rst_q;

  // R10: a reset write empties the link and raises the request next cycle
  a_r10_reset_effect: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reset |=> (board_rst && !ob_valid && !bd_omb_full && !bd_imb_full));

  // R2: an offered outbound entry stays offered and unchanged until taken
  a_r2_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (ob_valid && !ob_ready && !wr_reset) |=> (ob_valid && $stable(ob_data)));

endmodule

// File: tb/hostlink_if_test.sv
`timescale 1ns/1ps
module hostlink_if_test;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_mode = 1'b1;
  logic [2:0]  h_addr = '0;
  logic        h_wr = 1'b0, h_rd = 1'b0, h_hi_en = 1'b0;
  logic [15:0] h_wdata = '0;
  logic [15:0] h_rdata;
  logic        ob_valid, ob_ready = 1'b0;
  logic [15:0] ob_data;
  logic        ib_valid = 1'b0, ib_ready;
  logic [15:0] ib_data = '0;
  logic [5:0]  bd_omb_data;
  logic        bd_omb_full, bd_omb_take = 1'b0, bd_imb_put = 1'b0;
  logic [5:0]  bd_imb_data = '0;
  logic        bd_imb_full, bd_irq_enable = 1'b0, host_irq, board_rst;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hostlink_if #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode),
    .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd), .h_hi_en(h_hi_en),
    .h_wdata(h_wdata), .h_rdata(h_rdata),
    .ob_valid(ob_valid), .ob_ready(ob_ready), .ob_data(ob_data),
    .ib_valid(ib_valid), .ib_ready(ib_ready), .ib_data(ib_data),
    .bd_omb_data(bd_omb_data), .bd_omb_full(bd_omb_full), .bd_omb_take(bd_omb_take),
    .bd_imb_put(bd_imb_put), .bd_imb_data(bd_imb_data), .bd_imb_full(bd_imb_full),
    .bd_irq_enable(bd_irq_enable), .host_irq(host_irq), .board_rst(board_rst)
  );

  // reference model state
  logic [15:0] mq_ob[$];
  logic [15:0] mq_ib[$];
  logic [5:0]  m_omb = '0, m_imb = '0;
  bit          m_omb_full = 0, m_imb_full = 0, m_gate = 0, m_brst = 0;
  logic [7:0]  m_mask = '0;

  function automatic int m_limit();
    return word_mode ? DEPTH : DEPTH / 2;
  endfunction

  function automatic logic [7:0] m_status();
    int lim = m_limit();
    logic [7:0] s;
    s[7] = m_omb_full;
    s[6] = (mq_ob.size() >= lim);
    s[5] = (mq_ib.size() == 0);
    s[4] = (mq_ob.size() >= lim / 2);
    s[3] = (mq_ib.size() >= lim / 2);
    s[2] = m_imb_full;
    s[1] = (mq_ib.size() >= lim);
    s[0] = (mq_ob.size() == 0);
    return s;
  endfunction

  function automatic logic m_irq();
    logic [7:0] s = m_status();
    return m_gate && ((m_mask[6] && s[2]) || (m_mask[5] && s[1]) ||
                      (m_mask[3] && s[5]) || (m_mask[2] && s[6]) ||
                      (m_mask[0] && s[0]));
  endfunction

  function automatic logic [15:0] m_rdata();
    if (!h_rd) return 16'h0;
    case (h_addr)
      3'd0: begin
        if (mq_ib.size() == 0) return 16'h0;
        return h_hi_en ? mq_ib[0] : {8'h00, mq_ib[0][7:0]};
      end
      3'd2: return {8'h00, m_status()};
      3'd3: return {8'h00, (m_mask[7] ? m_omb : m_imb), 2'b00};
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2 ob_valid", {15'h0, ob_valid}, {15'h0, mq_ob.size() > 0});
    if (mq_ob.size() > 0) check("R2 ob_data", ob_data, mq_ob[0]);
    check("R4 ib_ready", {15'h0, ib_ready}, {15'h0, mq_ib.size() < m_limit()});
    case (h_addr)
      3'd0:    check("R3 offset 0 read", h_rdata, m_rdata());
      3'd2:    check("R5 status read", h_rdata, m_rdata());
      3'd3:    check("R8 mailbox read", h_rdata, m_rdata());
      3'd7:    check("R10 offset 7 read", h_rdata, m_rdata());
      default: check("R11 unused offset read", h_rdata, m_rdata());
    endcase
    check("R6 R7 host_irq", {15'h0, host_irq}, {15'h0, m_irq()});
    check("R9 omb_full", {15'h0, bd_omb_full}, {15'h0, m_omb_full});
    check("R8 omb_data", {10'h0, bd_omb_data}, {10'h0, m_omb});
    check("R9 imb_full", {15'h0, bd_imb_full}, {15'h0, m_imb_full});
    check("R10 board_rst", {15'h0, board_rst}, {15'h0, m_brst});
  endtask

  task automatic model_step();
    int lim = m_limit();
    int obn = mq_ob.size();
    int ibn = mq_ib.size();
    bit rsel_old = m_mask[7];
    bit wr7 = h_wr && (h_addr == 3'd7);
    m_brst = wr7;
    if (wr7) begin
      mq_ob.delete(); mq_ib.delete();
      m_omb = '0; m_imb = '0; m_omb_full = 0; m_imb_full = 0;
      m_mask = '0; m_gate = 0;
      return;
    end
    if (ob_ready && obn > 0) void'(mq_ob.pop_front());
    if (h_wr && h_addr == 3'd0 && obn < lim)
      mq_ob.push_back(h_hi_en ? h_wdata : {8'h00, h_wdata[7:0]});
    if (h_rd && h_addr == 3'd0 && ibn > 0) void'(mq_ib.pop_front());
    if (ib_valid && ibn < lim) mq_ib.push_back(ib_data);
    if (h_wr && h_addr == 3'd2) m_mask = h_wdata[7:0] & 8'hED;
    if (h_wr && h_addr == 3'd3) begin
      m_omb = h_wdata[7:2]; m_omb_full = 1;
    end else if (bd_omb_take) m_omb_full = 0;
    if (bd_imb_put) begin
      m_imb = bd_imb_data; m_imb_full = 1;
    end else if (h_rd && h_addr == 3'd3 && !rsel_old) m_imb_full = 0;
    if (bd_irq_enable) m_gate = 1;
  endtask

  task automatic tick();
    #1;
    compare_all();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle();
    h_wr = 0; h_rd = 0; h_hi_en = 0; h_addr = '0; h_wdata = '0;
    ob_ready = 0; ib_valid = 0; bd_omb_take = 0; bd_imb_put = 0; bd_irq_enable = 0;
  endtask

  task automatic hw(logic [2:0] a, logic [15:0] d, logic hi);
    h_wr = 1; h_addr = a; h_wdata = d; h_hi_en = hi;
    tick();
    idle();
  endtask

  task automatic hr(logic [2:0] a, logic hi);
    h_rd = 1; h_addr = a; h_hi_en = hi;
    tick();
    idle();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    h_rd = 1; h_addr = 3'd2;
    #1;
    check("R1 status after reset", h_rdata, 16'h0021);
    check("R1 host_irq after reset", {15'h0, host_irq}, 16'h0);
    check("R1 ob_valid after reset", {15'h0, ob_valid}, 16'h0);
    @(negedge clk);
    idle();
    tick();

    // R2: word and byte writes, board drains with back-pressure
    hw(3'd0, 16'hA55A, 1'b1);
    hw(3'd0, 16'hBEEF, 1'b0);
    tick(); tick();
    ob_ready = 1; tick(); tick(); idle(); tick();

    // R4: fill outbound in word mode, one extra push dropped
    for (int i = 0; i < DEPTH + 1; i++) hw(3'd0, 16'(16'h1000 + i), 1'b1);
    hr(3'd2, 1'b0);
    word_mode = 0; tick(); hr(3'd2, 1'b0);
    ob_ready = 1; repeat (DEPTH) tick(); idle();
    for (int i = 0; i < DEPTH / 2 + 2; i++) hw(3'd0, 16'(16'h2000 + i), 1'b1);
    hr(3'd2, 1'b0);
    ob_ready = 1; repeat (DEPTH) tick(); idle();
    word_mode = 1; tick();

    // R3/R4: inbound fill, word and byte reads, read while empty
    for (int i = 0; i < DEPTH + 2; i++) begin
      ib_valid = 1; ib_data = 16'(16'hC300 + i * 16'h0111); tick();
    end
    idle(); hr(3'd2, 1'b0);
    hr(3'd0, 1'b1); hr(3'd0, 1'b0);
    for (int i = 0; i < DEPTH; i++) hr(3'd0, 1'(i & 1));

    // R6/R7: mask and gate
    hw(3'd2, 16'h00FF, 1'b0); tick();
    bd_irq_enable = 1; tick(); idle(); tick();
    hw(3'd2, 16'h0008, 1'b0);
    ib_valid = 1; ib_data = 16'h0042; tick(); idle();
    hw(3'd2, 16'h0040, 1'b0);

    // R8/R9: mailboxes
    bd_imb_put = 1; bd_imb_data = 6'h2B; tick(); idle();
    hr(3'd3, 1'b0); hr(3'd3, 1'b0);
    hw(3'd3, 16'h00FF, 1'b0);
    hw(3'd2, 16'h0080, 1'b0);
    hr(3'd3, 1'b0);
    bd_omb_take = 1; tick(); idle();
    hr(3'd3, 1'b0);
    bd_imb_put = 1; bd_imb_data = 6'h15; tick(); idle();
    hr(3'd3, 1'b0);
    hw(3'd2, 16'h0000, 1'b0);
    h_rd = 1; h_addr = 3'd3; bd_imb_put = 1; bd_imb_data = 6'h3F; tick(); idle();

    // R11: unused offsets
    hw(3'd1, 16'hFFFF, 1'b1); hw(3'd4, 16'hFFFF, 1'b0);
    hw(3'd5, 16'hFFFF, 1'b0); hw(3'd6, 16'hFFFF, 1'b0);
    hr(3'd1, 1'b1); hr(3'd4, 1'b0); hr(3'd6, 1'b0);

    // R10: reset write with everything busy
    hw(3'd0, 16'h7777, 1'b1);
    hw(3'd3, 16'h00AC, 1'b0);
    bd_irq_enable = 1; tick(); idle();
    hr(3'd7, 1'b0);
    h_wr = 1; h_addr = 3'd7; bd_irq_enable = 1; tick(); idle();
    tick(); hr(3'd2, 1'b0);

    // mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 99);
      int ap = $urandom_range(0, 15);
      logic [2:0] a;
      if (ap < 6) a = 3'd0;
      else if (ap < 9) a = 3'd2;
      else if (ap < 12) a = 3'd3;
      else if (ap == 12) a = 3'd1;
      else if (ap == 13) a = 3'd5;
      else a = ($urandom_range(0, 7) == 0) ? 3'd7 : 3'd0;
      h_addr = a;
      h_wr = (op < 40);
      h_rd = (op >= 40 && op < 75);
      h_hi_en = 1'($urandom_range(0, 1));
      h_wdata = 16'($urandom());
      ob_ready = ($urandom_range(0, 2) == 0);
      ib_valid = ($urandom_range(0, 2) == 0);
      ib_data = 16'($urandom());
      bd_omb_take = ($urandom_range(0, 5) == 0);
      bd_imb_put = ($urandom_range(0, 5) == 0);
      bd_imb_data = 6'($urandom());
      bd_irq_enable = ($urandom_range(0, 30) == 0);
      if ($urandom_range(0, 200) == 0) word_mode = ~word_mode;
      tick();
    end
    idle();
    tick();

    done = 1;
    finish_run();
  end
endmodule